// File: doc/BRIEF.md
# Host-Driven Shared RAM Access Controller

This block gives an external host word access to an on-chip shared RAM through three small registers. The host writes a word address into the address register and moves data through the data register. The control register starts one-shot RAM writes and reads. A lock bit in the control register turns either command into a sticky burst mode. In that mode the RAM address steps up or down after every access, so the host can stream a block of words through the data register without reprogramming the address.

The host side is a simple synchronous register port. The host holds a select and presents an offset, a direction and write data. A transfer completes on the first rising clock edge at which the wait output is low. The RAM side is a single port with a write strobe, a read strobe and a read latency of one cycle. While a RAM access is in flight, the block reports busy and holds off every host access with the wait output.

Top module: `shram_host_ctl`

## Requirements
- R1: After reset, the control register reads 0, busy and wait are low, and neither RAM strobe is active.
- R2: The host register offsets are fixed: 0 is the address register, 1 is the data register and 2 is the control register. In the control register, bit 7 is lock, bit 5 is the write command, bit 3 is the read command and bit 0 is the step direction (1 = down). All other control bits read 0 and ignore writes.
- R3: A control write with bit 5 = 1 and bit 7 = 0 causes exactly one RAM write, in the cycle after the host write is accepted. The write stores the data register at the address register. Bit 5 then reads 0, and the address is unchanged.
- R4: A control write with bit 3 = 1 and bit 7 = 0 raises the RAM read strobe in the next cycle. The data register then holds the addressed word. Bit 3 then reads 0, and the address is unchanged.
- R5: A control write with both bit 5 and bit 3 set is ignored entirely. The control bits keep their values and no RAM access starts. The RAM write and read strobes are never active together.
- R6: A control write with bits 7 and 5 set performs one RAM write of the data register at the current address and then steps the address. Bit 5 stays 1 (continuous write mode).
- R7: In continuous write mode, each host write to the data register causes one RAM write of the new value at the current address, followed by an address step.
- R8: A control write with bits 7 and 3 set fetches the word at the current address into the data register without stepping. After that, each host read of the data register returns the held word, steps the address and fetches the next word (continuous read mode).
- R9: An address step adds 1 when bit 0 is 0 and subtracts 1 when bit 0 is 1, modulo 2^ADDR_W.
- R10: A control write with bit 7 = 0 and no command clears any held command bit and ends the burst mode. A control write with bit 7 = 1 and bit 5 = 0 also ends continuous write. After either write, data register accesses cause no RAM access and no address step.
- R11: Busy is high during every RAM access cycle. A host access presented while busy is high sees wait high and completes only after busy falls.
- R12: Outside continuous write mode, host writes to the address or data register cause no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostSel | input | 1 | Host transfer request |
| hostWr | input | 1 | 1 = register write, 0 = register read |
| hostAddr | input | 2 | Register offset |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Read data for the selected register |
| hostWait | output | 1 | Host transfer held off |
| busy | output | 1 | RAM access in flight |
| ramWrEn | output | 1 | RAM write strobe |
| ramRdEn | output | 1 | RAM read strobe (data one cycle later) |
| ramAddr | output | ADDR_W | RAM word address |
| ramWrData | output | DATA_W | RAM write data |
| ramRdData | input | DATA_W | RAM read data |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 32. The sixteen-word space lets a few burst accesses run the address across both ends of the range, so wrap-around is checked in both step directions. The full 32-bit data width keeps the reserved control bits, bits 31 to 8, present, so writing all of them to 1 and reading back 0 is meaningful.

// File: rtl/shram_host_pkg.sv
package shram_host_pkg;

  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2
  } regSel_e;

  localparam int BIT_LOCK = 7;
  localparam int BIT_WCMD = 5;
  localparam int BIT_RCMD = 3;
  localparam int BIT_DIR  = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic hostAcc;
    logic stepAddr;
    logic ramWr;
    logic ramRd;
    logic capture;
    logic clearCmd;
  } strobe_t;

  // held control bits
  typedef struct packed {
    logic lock;
    logic wrCmd;
    logic rdCmd;
    logic dirDown;
  } ctrlBits_t;

endpackage

// File: rtl/shram_host_ctrl.sv
module shram_host_ctrl
  import shram_host_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hostSel,
  input  logic      hostWr,
  input  logic [1:0] hostAddr,
  input  logic      newWrCmd,
  input  logic      newRdCmd,
  input  ctrlBits_t bits,
  output strobe_t   stb,
  output logic      busy,
  output logic      hostWait
);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_RDREQ, S_RDCAP} state_e;

  state_e state, stateNext;

  assign busy     = (state != S_IDLE);
  assign hostWait = hostSel && busy;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        stb.hostAcc = hostSel;
        if (hostSel) begin
          if (hostWr && hostAddr == REG_CTRL && !(newWrCmd && newRdCmd)) begin
            if (newWrCmd)      stateNext = S_WRITE;
            else if (newRdCmd) stateNext = S_RDREQ;
          end else if (hostWr && hostAddr == REG_DATA && bits.lock && bits.wrCmd) begin
            stateNext = S_WRITE;
          end else if (!hostWr && hostAddr == REG_DATA && bits.lock && bits.rdCmd) begin
            stb.stepAddr = 1'b1;
            stateNext    = S_RDREQ;
          end
        end
      end
      S_WRITE: begin
        stb.ramWr = 1'b1;
        if (bits.lock) stb.stepAddr = 1'b1;
        else           stb.clearCmd = 1'b1;
        stateNext = S_IDLE;
      end
      S_RDREQ: begin
        stb.ramRd = 1'b1;
        stateNext = S_RDCAP;
      end
      S_RDCAP: begin
        stb.capture = 1'b1;
        if (!bits.lock) stb.clearCmd = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

endmodule

// File: rtl/shram_host_dpath.sv
module shram_host_dpath
  import shram_host_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  strobe_t           stb,
  output ctrlBits_t         bits,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  input  logic [DATA_W-1:0] ramRdData
);

  localparam int CTRL_W = 8;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic              ctrlLegal;
  logic              wrAcc;
  logic [CTRL_W-1:0] ctrlWord;

  assign wrAcc     = stb.hostAcc && hostWr;
  assign ctrlLegal = !(hostWrData[BIT_WCMD] && hostWrData[BIT_RCMD]);

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
    end else if (wrAcc && hostAddr == REG_ADDR) begin
      addrReg <= hostWrData[ADDR_W-1:0];
    end else if (stb.stepAddr) begin
      addrReg <= bits.dirDown ? addrReg - ADDR_W'(1) : addrReg + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= '0;
    end else if (wrAcc && hostAddr == REG_DATA) begin
      dataReg <= hostWrData;
    end else if (stb.capture) begin
      dataReg <= ramRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
    end else if (wrAcc && hostAddr == REG_CTRL && ctrlLegal) begin
      bits.lock    <= hostWrData[BIT_LOCK];
      bits.wrCmd   <= hostWrData[BIT_WCMD];
      bits.rdCmd   <= hostWrData[BIT_RCMD];
      bits.dirDown <= hostWrData[BIT_DIR];
    end else if (stb.clearCmd) begin
      bits.wrCmd <= 1'b0;
      bits.rdCmd <= 1'b0;
    end
  end

  always_comb begin
    ctrlWord           = '0;
    ctrlWord[BIT_LOCK] = bits.lock;
    ctrlWord[BIT_WCMD] = bits.wrCmd;
    ctrlWord[BIT_RCMD] = bits.rdCmd;
    ctrlWord[BIT_DIR]  = bits.dirDown;
  end

  always_comb begin
    unique case (hostAddr)
      REG_ADDR: hostRdData = DATA_W'(addrReg);
      REG_DATA: hostRdData = dataReg;
      REG_CTRL: hostRdData = DATA_W'(ctrlWord);
      default:  hostRdData = '0;
    endcase
  end

  assign ramAddr   = addrReg;
  assign ramWrData = dataReg;

endmodule

// File: rtl/shram_host_ctl.sv
module shram_host_ctl
  import shram_host_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostWait,
  output logic              busy,
  output logic              ramWrEn,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  input  logic [DATA_W-1:0] ramRdData
);

  strobe_t   stb;
  ctrlBits_t ctlBits;

  shram_host_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .hostSel  (hostSel),
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .newWrCmd (hostWrData[BIT_WCMD]),
    .newRdCmd (hostWrData[BIT_RCMD]),
    .bits     (ctlBits),
    .stb      (stb),
    .busy     (busy),
    .hostWait (hostWait)
  );

  shram_host_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .hostWr     (hostWr),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .stb        (stb),
    .bits       (ctlBits),
    .ramAddr    (ramAddr),
    .ramWrData  (ramWrData),
    .ramRdData  (ramRdData)
  );

  assign ramWrEn = stb.ramWr;
  assign ramRdEn = stb.ramRd;

endmodule

// File: rtl/shram_host_chk.sv
module shram_host_chk
  import shram_host_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              hostSel,
  input logic              hostWr,
  input logic [1:0]        hostAddr,
  input logic [DATA_W-1:0] hostWrData,
  input logic [DATA_W-1:0] hostRdData,
  input logic              hostWait,
  input logic              busy,
  input logic              ramWrEn,
  input logic              ramRdEn,
  input logic [ADDR_W-1:0] ramAddr,
  input ctrlBits_t         bits
);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (hostAddr == REG_CTRL) |-> (hostRdData[DATA_W-1:8] == '0 && !hostRdData[6] &&
                                !hostRdData[4] && hostRdData[2:1] == 2'b00));

  a_r3_single_clears: assert property (@(posedge clk) disable iff (rst)
    (ramWrEn && !bits.lock) |=> !bits.wrCmd);

  a_r4_capture_follows: assert property (@(posedge clk) disable iff (rst)
    ramRdEn |=> (busy && !ramRdEn && !ramWrEn));

  a_r5_illegal_ignored: assert property (@(posedge clk) disable iff (rst)
    (hostSel && !hostWait && hostWr && hostAddr == REG_CTRL &&
     hostWrData[BIT_WCMD] && hostWrData[BIT_RCMD])
    |=> (!ramWrEn && !ramRdEn && $stable(bits)));

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ramWrEn && ramRdEn));

  a_r9_burst_step: assert property (@(posedge clk) disable iff (rst)
    (ramWrEn && bits.lock) |=>
      (ramAddr == ($past(bits.dirDown) ? $past(ramAddr) - ADDR_W'(1)
                                       : $past(ramAddr) + ADDR_W'(1))));

  a_r11_wait_when_busy: assert property (@(posedge clk) disable iff (rst)
    (hostSel && busy) |-> hostWait);

  a_r11_busy_on_access: assert property (@(posedge clk) disable iff (rst)
    (ramWrEn || ramRdEn) |-> busy);

endmodule

bind shram_host_ctl shram_host_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hostSel    (hostSel),
  .hostWr     (hostWr),
  .hostAddr   (hostAddr),
  .hostWrData (hostWrData),
  .hostRdData (hostRdData),
  .hostWait   (hostWait),
  .busy       (busy),
  .ramWrEn    (ramWrEn),
  .ramRdEn    (ramRdEn),
  .ramAddr    (ramAddr),
  .bits       (ctlBits)
);

// File: tb/test_shram_host_ctl.sv
module test_shram_host_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hostSel = 1'b0;
  logic          hostWr = 1'b0;
  logic [1:0]    hostAddr = 2'd0;
  logic [DW-1:0] hostWrData = '0;
  logic [DW-1:0] hostRdData;
  logic          hostWait;
  logic          busy;
  logic          ramWrEn;
  logic          ramRdEn;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWrData;
  logic [DW-1:0] ramRdData = '0;

  int nChecks = 0;
  int nBad = 0;

  logic [DW-1:0]    mem    [WORDS];
  logic [DW-1:0]    expMem [WORDS];
  logic [AW+DW-1:0] expQ   [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shram_host_ctl #(.ADDR_W(AW), .DATA_W(DW)) i_shram_host_ctl (
    .clk(clk), .rst(rst), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostWait(hostWait), .busy(busy),
    .ramWrEn(ramWrEn), .ramRdEn(ramRdEn), .ramAddr(ramAddr), .ramWrData(ramWrData),
    .ramRdData(ramRdData)
  );

  // RAM model, one cycle read latency
  always @(posedge clk) begin
    if (ramWrEn) mem[ramAddr] <= ramWrData;
    if (ramRdEn) ramRdData <= mem[ramAddr];
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every RAM write must match the next expected item
  always @(posedge clk) begin
    if (!rst && ramWrEn) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R12: actual=unexpected write %h@%h expected=no write", ramWrData, ramAddr);
      end else begin
        logic [AW+DW-1:0] e;
        e = expQ.pop_front();
        if ({ramAddr, ramWrData} !== e) begin
          nBad++;
          $display("FAIL R3/R7: actual=%h expected=%h", {ramAddr, ramWrData}, e);
        end
      end
    end
  end

  task automatic expectWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    expQ.push_back({a, d});
    expMem[a] = d;
  endtask

  task automatic hostXfer(input logic [1:0] a, input logic wr, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rdv, output logic waited);
    @(negedge clk);
    hostSel = 1'b1; hostWr = wr; hostAddr = a; hostWrData = wd;
    #1;
    waited = 1'b0;
    while (hostWait) begin
      waited = 1'b1;
      @(negedge clk);
      #1;
    end
    rdv = hostRdData;
    @(posedge clk);
    #1;
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] r; logic w;
    hostXfer(a, 1'b1, d, r, w);
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [DW-1:0] r);
    logic w;
    hostXfer(a, 1'b0, '0, r, w);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [DW-1:0] r;
    logic w;
    for (int i = 0; i < WORDS; i++) begin
      mem[i]    = 32'h1000_0000 + i * 32'h11;
      expMem[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 strobes", {30'd0, ramWrEn, ramRdEn}, 32'd0);
    rdReg(2'd2, r);
    chk("R1 ctrl", r, 32'd0);

    // R2 reserved bits ignore writes
    wrReg(2'd2, 32'hFFFF_FF56);
    rdReg(2'd2, r);
    chk("R2 reserved", r, 32'd0);

    // R3 single write at 3
    wrReg(2'd0, 32'd3);
    wrReg(2'd1, 32'hA5A5_0003);
    expectWrite(4'd3, 32'hA5A5_0003);
    wrReg(2'd2, 32'h20);
    @(negedge clk);
    chk("R3 write strobe next cycle", {31'd0, ramWrEn}, 32'd1);
    rdReg(2'd2, r);
    chk("R3 cmd cleared", r, 32'd0);
    rdReg(2'd0, r);
    chk("R3 addr kept", r, 32'd3);

    // R4 single read at 3
    wrReg(2'd1, 32'h0);
    wrReg(2'd2, 32'h08);
    @(negedge clk);
    chk("R4 read strobe next cycle", {31'd0, ramRdEn}, 32'd1);
    rdReg(2'd1, r);
    chk("R4 data", r, expMem[3]);
    rdReg(2'd2, r);
    chk("R4 cmd cleared", r, 32'd0);
    rdReg(2'd0, r);
    chk("R4 addr kept", r, 32'd3);

    // R5 illegal command
    wrReg(2'd2, 32'h28);
    @(negedge clk);
    chk("R5 no access", {30'd0, ramWrEn, ramRdEn}, 32'd0);
    rdReg(2'd2, r);
    chk("R5 ctrl unchanged", r, 32'd0);

    // R6/R7/R11 continuous write upward from 5
    wrReg(2'd0, 32'd5);
    wrReg(2'd1, 32'hD000_0000);
    expectWrite(4'd5, 32'hD000_0000);
    wrReg(2'd2, 32'hA0);
    rdReg(2'd2, r);
    chk("R6 mode held", r, 32'hA0);
    expectWrite(4'd6, 32'hD000_0001);
    wrReg(2'd1, 32'hD000_0001);
    @(negedge clk);
    chk("R11 busy during write", {31'd0, busy}, 32'd1);
    expectWrite(4'd7, 32'hD000_0002);
    wrReg(2'd1, 32'hD000_0002);
    expectWrite(4'd8, 32'hD000_0003);
    hostXfer(2'd1, 1'b1, 32'hD000_0003, r, w);
    hostXfer(2'd1, 1'b0, '0, r, w);
    chk("R11 waited behind busy", {31'd0, w}, 32'd1);
    chk("R11 read after wait", r, 32'hD000_0003);
    rdReg(2'd0, r);
    chk("R7 addr stepped", r, 32'd9);
    wrReg(2'd2, 32'h00);
    rdReg(2'd2, r);
    chk("R10 lock cleared", r, 32'd0);

    // R12 data write in normal mode: scoreboard flags any RAM write
    wrReg(2'd1, 32'hBEEF_0000);
    rdReg(2'd0, r);
    chk("R12 addr unchanged", r, 32'd9);

    // R9 continuous write downward with wrap
    wrReg(2'd0, 32'd1);
    wrReg(2'd1, 32'hE000_0001);
    expectWrite(4'd1, 32'hE000_0001);
    wrReg(2'd2, 32'hA1);
    expectWrite(4'd0, 32'hE000_0000);
    wrReg(2'd1, 32'hE000_0000);
    expectWrite(4'd15, 32'hE000_000F);
    wrReg(2'd1, 32'hE000_000F);
    rdReg(2'd0, r);
    chk("R9 down wrap", r, 32'd14);
    // R10 drop write command while lock stays
    wrReg(2'd2, 32'h81);
    rdReg(2'd2, r);
    chk("R10 write bit dropped", r, 32'h81);
    wrReg(2'd1, 32'hE000_00EE);
    rdReg(2'd0, r);
    chk("R10 no step after drop", r, 32'd14);
    wrReg(2'd2, 32'h00);

    // R8 continuous read upward from 14 wrapping
    repeat (2) @(negedge clk);
    wrReg(2'd0, 32'd14);
    wrReg(2'd2, 32'h88);
    rdReg(2'd1, r);
    chk("R8 word 14", r, expMem[14]);
    rdReg(2'd1, r);
    chk("R8 word 15", r, expMem[15]);
    rdReg(2'd1, r);
    chk("R9 up wrap word 0", r, expMem[0]);
    rdReg(2'd2, r);
    chk("R8 mode held", r, 32'h88);
    wrReg(2'd2, 32'h00);
    rdReg(2'd0, r);
    chk("R8 addr after reads", r, 32'd1);
    rdReg(2'd1, r);
    chk("R10 prefetched word held", r, expMem[1]);
    rdReg(2'd0, r);
    chk("R10 no step after exit", r, 32'd1);

    repeat (3) @(negedge clk);
    chk("R12 all expected writes seen", expQ.size(), 32'd0);
    for (int i = 0; i < WORDS; i++) chk("R7 RAM contents", mem[i], expMem[i]);
    finishRun();
  end

endmodule